// File: doc/BRIEF.md
# Power-Down Mode Controller

This block decides when a network controller enters and leaves its low-power state. Two request sources exist. The first is a dedicated power-down input pin. The second is a control bit that software writes through a simple register write port.

The two sources follow different exit rules:

- **Pin request.** It lasts only while the pin is held high. It is overridden at once by the raw reset input or by a soft-reset bit in a configuration register.
- **Control bit.** It stays set until any register write or a hardware reset clears it.

From the active request, the block produces registered, active-high enables for the following:

- the oscillator
- the data-bus drivers
- the 16-bit chip-select output
- the line-driver outputs
- the analog bias
- the serial-memory outputs
- the interrupt outputs

The interrupt drivers are released only for a bit-driven power-down. When no request is active, an encoder-select input chooses between external-encoder and internal-encoder operation. A 2-bit mode code reports which of the four states is current.

A deglitcher filters the reset input. Every internal use of reset takes the filtered version, except the pin-request override, which uses the raw input. This keeps the oscillator running for the whole of a reset pulse. Entering or leaving power-down never clears register state.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While the filtered reset is asserted, on the next clock every enable is high and `mode` is 2'b00, whatever `enc_sel` is. The control bit and the soft-reset bit are cleared, and writes are ignored.
- R2: With no active request, `mode` follows `enc_sel` one clock later: 2'b00 for external encoder (`enc_sel`=0) and 2'b01 for internal encoder (`enc_sel`=1). All enables are high.
- R3: One clock after an ungated `pd_pin` is seen high, `mode` is 2'b10. In that state `osc_en`, `bus_oe`, `cs16_oe`, `line_oe`, `bias_en` and `smem_en` are low, and `irq_oe` stays high.
- R4: Once `pd_pin` goes low with no control-bit request, normal mode returns on the next clock.
- R5: A write to `CTRL_ADDR` with data bit 13 set sets the control bit. From the clock after the write, `mode` is 2'b11 and all seven enables, including `irq_oe`, are low.
- R6: Any register write clears the control bit. This covers a write to another address and a write to `CTRL_ADDR` with bit 13 clear.
- R7: Config register bit 7 (at `CFG_ADDR`) is the soft-reset bit. While it is set, a high `pd_pin` does not cause power-down.
- R8: While the raw `rst_in` is high, `pd_pin` is ignored from the very next clock, with no deglitch delay.
- R9: The filtered reset changes state only after `rst_in` has differed from it for 4 consecutive clocks. A shorter pulse leaves the control bit intact.
- R10: When the control bit and the pin are both active, `mode` is 2'b11 and `irq_oe` is low.
- R11: The soft-reset bit keeps its value across power-down entry and exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Raw active-high reset, deglitched inside |
| pd_pin | input | 1 | Power-down request pin |
| enc_sel | input | 1 | Encoder select: 0 external, 1 internal |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| osc_en | output | 1 | Oscillator enable |
| bus_oe | output | 1 | Data-bus driver enable |
| cs16_oe | output | 1 | 16-bit chip-select driver enable |
| line_oe | output | 1 | Line-driver output enable |
| bias_en | output | 1 | Analog bias enable |
| smem_en | output | 1 | Serial-memory outputs active |
| irq_oe | output | 1 | Interrupt driver enable |
| mode | output | 2 | 00 ext, 01 int, 10 pin power-down, 11 bit power-down |

## Verification
The hardest state to reach is a short raw reset pulse that overlaps a pending power-down. The pulse must mask the pin at once but must be too short to reach the filtered reset, so no register state is lost.

The stimulus covers this in two ways. It holds `rst_in` high for two clocks during a pin power-down, then for three clocks during a bit power-down. It then extends the pulse to four clocks to show where filtering ends and the control bit is cleared. A separate sequence sets the soft-reset bit and then sets and clears the control bit around it, which shows that the soft-reset bit survives power-down entry and exit.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [1:0] {
    MODE_EXT = 2'b00,
    MODE_INT = 2'b01,
    MODE_PIN = 2'b10,
    MODE_BIT = 2'b11
  } mode_t;

  localparam int PD_BIT_POS   = 13;
  localparam int SRST_BIT_POS = 7;

  localparam int NUM_EN  = 7;
  localparam int EN_OSC  = 0;
  localparam int EN_BUS  = 1;
  localparam int EN_CS16 = 2;
  localparam int EN_LINE = 3;
  localparam int EN_BIAS = 4;
  localparam int EN_SMEM = 5;
  localparam int EN_IRQ  = 6;

  // enables dropped by a pin-driven power-down (interrupts stay driven)
  localparam logic [NUM_EN-1:0] PIN_OFF_MASK = 7'b011_1111;
endpackage

// File: rtl/pwrdn_deglitch.sv
module pwrdn_deglitch #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(STABLE + 1);

  logic          filt_q = 1'b1;
  logic [CW-1:0] cnt_q  = '0;

  always_ff @(posedge clk) begin
    if (raw == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(STABLE - 1)) begin
      filt_q <= raw;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt = filt_q;
endmodule

// File: rtl/pwrdn_regs.sv
module pwrdn_regs
  import pwrdn_pkg::*;
#(
  parameter int            AW        = 4,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] CTRL_ADDR = '0,
  parameter logic [AW-1:0] CFG_ADDR  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          pd_bit,
  output logic          srst
);
  logic pd_q, srst_q;

  // any write clears the power-down bit unless it is a control write setting it
  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q <= 1'b0;
    end else if (wr_en) begin
      pd_q <= (wr_addr == CTRL_ADDR) && wr_data[PD_BIT_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srst_q <= 1'b0;
    end else if (wr_en && (wr_addr == CFG_ADDR)) begin
      srst_q <= wr_data[SRST_BIT_POS];
    end
  end

  assign pd_bit = pd_q;
  assign srst   = srst_q;
endmodule

// File: rtl/pwrdn_outs.sv
module pwrdn_outs
  import pwrdn_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_req,
  input  logic              bit_req,
  input  logic              enc_sel,
  output logic [NUM_EN-1:0] en,
  output logic [1:0]        mode
);
  mode_t mode_d, mode_q;

  always_comb begin
    if (bit_req)      mode_d = MODE_BIT;
    else if (pin_req) mode_d = MODE_PIN;
    else if (enc_sel) mode_d = MODE_INT;
    else              mode_d = MODE_EXT;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_EXT;
    else     mode_q <= mode_d;
  end

  for (genvar gi = 0; gi < NUM_EN; gi++) begin : g_en
    logic en_q;
    always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b1;
      else     en_q <= ~(bit_req | (pin_req & PIN_OFF_MASK[gi]));
    end
    assign en[gi] = en_q;
  end

  assign mode = mode_q;
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int            AW        = 4,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 4'h0,
  parameter logic [AW-1:0] CFG_ADDR  = 4'h8,
  parameter int            STABLE    = 4
) (
  input  logic          clk,
  input  logic          rst_in,
  input  logic          pd_pin,
  input  logic          enc_sel,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          osc_en,
  output logic          bus_oe,
  output logic          cs16_oe,
  output logic          line_oe,
  output logic          bias_en,
  output logic          smem_en,
  output logic          irq_oe,
  output logic [1:0]    mode
);
  logic              rst_f;
  logic              pd_bit_q;
  logic              srst_q;
  logic              pin_req;
  logic [NUM_EN-1:0] en;

  pwrdn_deglitch #(.STABLE(STABLE)) u_dg (
    .clk  (clk),
    .raw  (rst_in),
    .filt (rst_f)
  );

  pwrdn_regs #(
    .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_regs (
    .clk     (clk),
    .rst     (rst_f),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pd_bit  (pd_bit_q),
    .srst    (srst_q)
  );

  // pin request masked by the raw (unfiltered) reset and by soft reset
  assign pin_req = pd_pin & ~rst_in & ~srst_q;

  pwrdn_outs u_outs (
    .clk     (clk),
    .rst     (rst_f),
    .pin_req (pin_req),
    .bit_req (pd_bit_q),
    .enc_sel (enc_sel),
    .en      (en),
    .mode    (mode)
  );

  assign osc_en  = en[EN_OSC];
  assign bus_oe  = en[EN_BUS];
  assign cs16_oe = en[EN_CS16];
  assign line_oe = en[EN_LINE];
  assign bias_en = en[EN_BIAS];
  assign smem_en = en[EN_SMEM];
  assign irq_oe  = en[EN_IRQ];
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk #(
  parameter int            AW        = 4,
  parameter logic [AW-1:0] CTRL_ADDR = '0
) (
  input logic          clk,
  input logic          rst_in,
  input logic          rst_f,
  input logic          pd_pin,
  input logic          srst,
  input logic          pd_bit,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [1:0]    mode,
  input logic          irq_oe,
  input logic          osc_en
);
  AST_RESET_NORMAL: assert property (@(posedge clk) rst_f |=> (mode == 2'b00 && osc_en && irq_oe)); // R1
  AST_NORMAL_EXIT: assert property (@(posedge clk) disable iff (rst_f) (!pd_pin && !pd_bit) |=> !mode[1]); // R4
  AST_PIN_ENTRY: assert property (@(posedge clk) disable iff (rst_f) (pd_pin && !rst_in && !srst) |=> mode[1]); // R3
  AST_PIN_IRQ_KEPT: assert property (@(posedge clk) disable iff (rst_f) (mode == 2'b10) |-> (irq_oe && !osc_en)); // R3
  AST_BIT_ENTRY: assert property (@(posedge clk) disable iff (rst_f) pd_bit |=> (mode == 2'b11 && !irq_oe)); // R5
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst_f) (wr_en && wr_addr != CTRL_ADDR) |=> !pd_bit); // R6
  AST_SRST_BLOCKS: assert property (@(posedge clk) disable iff (rst_f) (srst && !pd_bit) |=> !mode[1]); // R7
  AST_RAW_BLOCKS: assert property (@(posedge clk) disable iff (rst_f) (rst_in && !pd_bit) |=> !mode[1]); // R8
  AST_DEGLITCH_HOLD: assert property (@(posedge clk) (!rst_f && !rst_in) |=> !rst_f); // R9
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk #(.AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk     (clk),
  .rst_in  (rst_in),
  .rst_f   (rst_f),
  .pd_pin  (pd_pin),
  .srst    (srst_q),
  .pd_bit  (pd_bit_q),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .mode    (mode),
  .irq_oe  (irq_oe),
  .osc_en  (osc_en)
);

// File: tb/pwrdn_ctrl_bench.sv
module pwrdn_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam logic [AW-1:0] CTRL_A = 4'h0;
  localparam logic [AW-1:0] CFG_A  = 4'h8;
  localparam logic [6:0] EN_ALL = 7'h7F;
  localparam logic [6:0] EN_PIN = 7'h40;
  localparam logic [6:0] EN_OFF = 7'h00;
  localparam int NV = 8;
  // {pd_pin, enc_sel, mode[1:0], enables {irq,smem,bias,line,cs16,bus,osc}}
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'b00, 7'h7F},
    {1'b0, 1'b1, 2'b01, 7'h7F},
    {1'b1, 1'b1, 2'b10, 7'h40},
    {1'b1, 1'b0, 2'b10, 7'h40},
    {1'b0, 1'b0, 2'b00, 7'h7F},
    {1'b1, 1'b0, 2'b10, 7'h40},
    {1'b0, 1'b1, 2'b01, 7'h7F},
    {1'b0, 1'b0, 2'b00, 7'h7F}
  };

  logic          clk = 1'b0;
  logic          rst_in, pd_pin, enc_sel, wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          osc_en, bus_oe, cs16_oe, line_oe, bias_en, smem_en, irq_oe;
  logic [1:0]    mode;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwrdn_ctrl #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_A), .CFG_ADDR(CFG_A)) u_pwrdn_ctrl (
    .clk(clk), .rst_in(rst_in), .pd_pin(pd_pin), .enc_sel(enc_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .osc_en(osc_en), .bus_oe(bus_oe), .cs16_oe(cs16_oe), .line_oe(line_oe),
    .bias_en(bias_en), .smem_en(smem_en), .irq_oe(irq_oe), .mode(mode)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [1:0] m_exp, input logic [6:0] e_exp);
    logic [6:0] e_act;
    e_act = {irq_oe, smem_en, bias_en, line_oe, cs16_oe, bus_oe, osc_en};
    n_chk++;
    if (mode !== m_exp || e_act !== e_exp) begin
      n_fail++;
      $display("FAIL %s: mode=%b en=%b expected mode=%b en=%b", tag, mode, e_act, m_exp, e_exp);
    end
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  initial begin
    rst_in = 1'b1; pd_pin = 1'b0; enc_sel = 1'b1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    @(negedge clk);
    repeat (6) tick();
    check("R1 reset state", 2'b00, EN_ALL);
    rst_in = 1'b0;
    repeat (6) tick();

    for (int i = 0; i < NV; i++) begin
      pd_pin  = VEC[i][10];
      enc_sel = VEC[i][9];
      tick();
      check($sformatf("R2/R3/R4 vector %0d", i), VEC[i][8:7], VEC[i][6:0]);
    end

    // R5: control bit set by write, bit 13
    enc_sel = 1'b0;
    reg_write(CTRL_A, 16'h2000);
    tick();
    check("R5 bit power-down", 2'b11, EN_OFF);
    // R10: bit wins over pin
    pd_pin = 1'b1;
    tick();
    check("R10 bit over pin", 2'b11, EN_OFF);
    pd_pin = 1'b0;
    // R6: write to another address clears
    reg_write(4'h3, 16'h0000);
    tick();
    check("R6 other-address write clears", 2'b00, EN_ALL);
    reg_write(CTRL_A, 16'h2000);
    tick();
    reg_write(CTRL_A, 16'h0000);
    tick();
    check("R6 control write bit13=0 clears", 2'b00, EN_ALL);

    // R7: soft reset blocks pin
    reg_write(CFG_A, 16'h0080);
    pd_pin = 1'b1;
    tick();
    tick();
    check("R7 soft reset masks pin", 2'b00, EN_ALL);
    // R11: soft reset survives bit power-down entry/exit
    reg_write(CTRL_A, 16'h2000);
    tick();
    check("R11 bit power-down with soft reset", 2'b11, EN_OFF);
    reg_write(CTRL_A, 16'h0000);
    tick();
    check("R11 soft reset kept after exit", 2'b00, EN_ALL);
    reg_write(CFG_A, 16'h0000);
    tick();
    check("R7 soft reset cleared, pin acts", 2'b10, EN_PIN);

    // R8: raw reset masks pin at once, short pulse
    rst_in = 1'b1;
    tick();
    check("R8 raw reset masks pin", 2'b00, EN_ALL);
    tick();
    rst_in = 1'b0;
    tick();
    check("R8 pin resumes after short pulse", 2'b10, EN_PIN);
    pd_pin = 1'b0;

    // R9: 3-cycle pulse keeps control bit, 4+ cycles resets
    reg_write(CTRL_A, 16'h2000);
    tick();
    check("R9 bit set before pulse", 2'b11, EN_OFF);
    rst_in = 1'b1;
    repeat (3) tick();
    rst_in = 1'b0;
    tick();
    check("R9 3-cycle pulse filtered", 2'b11, EN_OFF);
    rst_in = 1'b1;
    enc_sel = 1'b1;
    repeat (4) tick();
    tick();
    check("R9 4-cycle pulse reaches reset (R1)", 2'b00, EN_ALL);
    reg_write(CTRL_A, 16'h2000);
    tick();
    check("R1 write ignored in reset", 2'b00, EN_ALL);
    rst_in = 1'b0;
    repeat (6) tick();
    check("R9 control bit cleared by reset", 2'b01, EN_ALL);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule